// File: doc/BRIEF.md
# Stereo Soft Mute Gain Ramp

This block sits in a stereo audio datapath and fades a pair of 24-bit two's complement samples in and out without a click. A single gain level is shared by both channels. Each time the frame strobe pulses, the gain moves one step toward silence while the mute request is high, or toward unity while it is low. The scaled samples appear on registered outputs.

The step size follows a two-bit speed code, so a complete fade always spans a number of frames that matches the sample rate class. At the normal rate it takes 1024 frames, at the double rate 2048, and at the quad rate 4096. Dropping the request part way through a fade does not restart it. The gain turns around at the level already reached and climbs back from there at the same rate. A status output goes high while the gain sits at zero.

Top module: `smute_attenuator`

## Requirements
- R1: A synchronous active-high reset sets the gain to unity (4096) and clears both sample outputs and the full-attenuation flag.
- R2: With the mute request high and speed code 2'b00 (normal), every frame strobe lowers the gain by 4, so the flag first goes high on the 1024th strobe counted from unity.
- R3: Speed code 2'b01 (double) uses a step of 2 and needs 2048 strobes for a full fade. Speed code 2'b10 (quad) uses a step of 1 and needs 4096. Code 2'b11 acts as quad.
- R4: With the request low, every strobe raises the gain by the step of the current speed code, saturating at unity. A release from zero gain is back to unity after the same number of strobes as the fade down.
- R5: A release during a fade climbs back from the level already reached. After N strobes down followed by N strobes up at one speed, the gain is unity again.
- R6: On each strobe both outputs load floor((x*G + 2048) / 4096), where x is the signed input and G the gain before that strobe's update. The new value is visible after that clock edge.
- R7: Left and right use the same gain on the same strobe, including when the two inputs differ.
- R8: At unity, 0x7FFFFF, 0x800000 and 0x000000 pass through unchanged. At zero gain both outputs are 0x000000.
- R9: Without a strobe, the gain and both outputs hold, whatever the inputs and the request do.
- R10: The full-attenuation flag is high exactly while the gain is zero. It drops after the first strobe that raises the gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse per stereo frame; advances ramp and loads outputs |
| mute_req | input | 1 | High: fade toward zero gain; low: fade toward unity |
| speed_sel | input | 2 | Rate class: 00 normal, 01 double, 10 quad, 11 quad |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_left | output | 24 | Scaled left sample, registered |
| out_right | output | 24 | Scaled right sample, registered |
| full_atten | output | 1 | High while gain is zero |

## Verification
The scaling path is driven at unity with full-scale positive, full-scale negative, zero and unequal left/right words. This separates exact pass-through from sign or rounding faults and catches channels that are swapped or share the wrong gain. Complete fades are run at each speed code, with a constant full-scale pair, and every frame is compared against a gain model. This pins down the step size, the strobe on which the flag rises and the monotone shape of the ramp. A short fade followed by an early release shows whether the counter turns around or restarts. Idle cycles with changing inputs and a reset in mid-fade check the hold behaviour and the restart state.

// File: rtl/smute_pkg.sv
package smute_pkg;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_QUAD_X = 2'b11
    } speed_e;

    // Gain step per frame: unity/(frames of a full fade at this rate).
    function automatic int ramp_step(speed_e spd, int unity, int base_frames);
        case (spd)
            SPD_NORMAL: return unity / base_frames;
            SPD_DOUBLE: return unity / (2 * base_frames);
            default:    return unity / (4 * base_frames);
        endcase
    endfunction

endpackage

// File: rtl/smute_gain_ramp.sv
module smute_gain_ramp
    import smute_pkg::*;
#(
    parameter int GAIN_FRAC   = 12,
    parameter int BASE_FRAMES = 1024,
    localparam int GAIN_W     = GAIN_FRAC + 1,
    localparam int UNITY      = 1 << GAIN_FRAC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              mute,
    input  speed_e            speed,
    output logic [GAIN_W-1:0] gain,
    output logic              at_floor
);
    localparam int EXT_W = GAIN_W + 1;

    logic [GAIN_W-1:0] gain_q;
    logic [GAIN_W-1:0] gain_d;
    logic [EXT_W-1:0]  step;
    logic [EXT_W-1:0]  headroom;

    always_comb begin
        step     = EXT_W'(ramp_step(speed, UNITY, BASE_FRAMES));
        headroom = EXT_W'(UNITY) - {1'b0, gain_q};
        if (mute) begin
            // Fall toward zero, turning around from any level reached.
            if ({1'b0, gain_q} > step)
                gain_d = gain_q - step[GAIN_W-1:0];
            else
                gain_d = '0;
        end else begin
            if (headroom > step)
                gain_d = gain_q + step[GAIN_W-1:0];
            else
                gain_d = GAIN_W'(UNITY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            gain_q <= GAIN_W'(UNITY);
        else if (adv)
            gain_q <= gain_d;
    end

    assign gain     = gain_q;
    assign at_floor = (gain_q == '0);

endmodule

// File: rtl/smute_scale.sv
module smute_scale #(
    parameter int SAMPLE_W  = 24,
    parameter int GAIN_FRAC = 12,
    localparam int GAIN_W   = GAIN_FRAC + 1,
    localparam int PROD_W   = SAMPLE_W + GAIN_W + 1
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [GAIN_W-1:0]   gain,
    output logic [SAMPLE_W-1:0] scaled
);
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (GAIN_FRAC - 1);

    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] g_ext;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        s_ext  = PROD_W'($signed(sample));
        g_ext  = PROD_W'($signed({1'b0, gain}));
        prod   = s_ext * g_ext + HALF;
        // Gain never exceeds unity, so the shifted product fits the sample width.
        scaled = prod[GAIN_FRAC +: SAMPLE_W];
    end

endmodule

// File: rtl/smute_attenuator.sv
module smute_attenuator
    import smute_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int GAIN_FRAC   = 12,
    parameter int BASE_FRAMES = 1024,
    localparam int GAIN_W     = GAIN_FRAC + 1,
    localparam int N_CH       = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_stb,
    input  logic                mute_req,
    input  logic [1:0]          speed_sel,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                full_atten
);
    logic [GAIN_W-1:0]   gain_q;
    logic [SAMPLE_W-1:0] ch_in  [N_CH];
    logic [SAMPLE_W-1:0] ch_q   [N_CH];

    smute_gain_ramp #(
        .GAIN_FRAC  (GAIN_FRAC),
        .BASE_FRAMES(BASE_FRAMES)
    ) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .adv     (frame_stb),
        .mute    (mute_req),
        .speed   (speed_e'(speed_sel)),
        .gain    (gain_q),
        .at_floor(full_atten)
    );

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [SAMPLE_W-1:0] scaled;

        smute_scale #(
            .SAMPLE_W (SAMPLE_W),
            .GAIN_FRAC(GAIN_FRAC)
        ) u_scale (
            .sample(ch_in[c]),
            .gain  (gain_q),
            .scaled(scaled)
        );

        always_ff @(posedge clk) begin
            if (rst)
                ch_q[c] <= '0;
            else if (frame_stb)
                ch_q[c] <= scaled;
        end
    end

    assign out_left  = ch_q[0];
    assign out_right = ch_q[1];

endmodule

// File: rtl/smute_attenuator_chk.sv
module smute_attenuator_chk #(
    parameter int SAMPLE_W    = 24,
    parameter int GAIN_FRAC   = 12,
    parameter int BASE_FRAMES = 1024,
    localparam int GAIN_W     = GAIN_FRAC + 1,
    localparam int UNITY      = 1 << GAIN_FRAC,
    localparam int MAX_STEP   = UNITY / BASE_FRAMES
) (
    input logic                clk,
    input logic                rst,
    input logic                frame_stb,
    input logic                mute_req,
    input logic [GAIN_W-1:0]   gain_q,
    input logic [SAMPLE_W-1:0] in_left,
    input logic [SAMPLE_W-1:0] in_right,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right,
    input logic                full_atten
);
    // R2: a muted strobe never raises the gain and lowers it by at most one normal step
    a_r2_fall_step: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && mute_req) |=>
            (gain_q <= $past(gain_q)) &&
            (int'($past(gain_q)) - int'(gain_q) <= MAX_STEP));

    // R4: a released strobe never lowers the gain
    a_r4_rise_mono: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !mute_req) |=> gain_q >= $past(gain_q));

    // R4: the gain stays within unity
    a_r4_bounded: assert property (@(posedge clk) disable iff (rst)
        int'(gain_q) <= UNITY);

    // R8: unity gain passes both words unchanged
    a_r8_unity_pass: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && int'(gain_q) == UNITY) |=>
            (out_left == $past(in_left)) && (out_right == $past(in_right)));

    // R8: a strobe at zero gain produces silence on both channels
    a_r8_floor_silent: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && full_atten) |=> (out_left == '0) && (out_right == '0));

    // R9: without a strobe nothing moves
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(gain_q) && $stable(out_left) && $stable(out_right));

endmodule

bind smute_attenuator smute_attenuator_chk #(
    .SAMPLE_W   (SAMPLE_W),
    .GAIN_FRAC  (GAIN_FRAC),
    .BASE_FRAMES(BASE_FRAMES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .mute_req  (mute_req),
    .gain_q    (gain_q),
    .in_left   (in_left),
    .in_right  (in_right),
    .out_left  (out_left),
    .out_right (out_right),
    .full_atten(full_atten)
);

// File: tb/test_smute_attenuator.sv
module test_smute_attenuator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic        mute_req = 1'b0;
    logic [1:0]  speed_sel = 2'b00;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic [23:0] out_left;
    logic [23:0] out_right;
    logic        full_atten;

    int n_cmp = 0;
    int n_bad = 0;
    int gm    = 4096;   // bench gain model
    bit done  = 1'b0;

    always #2 clk = ~clk;

    smute_attenuator i_smute_attenuator (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .mute_req  (mute_req),
        .speed_sel (speed_sel),
        .in_left   (in_left),
        .in_right  (in_right),
        .out_left  (out_left),
        .out_right (out_right),
        .full_atten(full_atten)
    );

    localparam int NVEC = 6;
    localparam logic [47:0] UNITY_VEC [NVEC] = '{
        {24'h7FFFFF, 24'h800000},
        {24'h000000, 24'h000001},
        {24'h123456, 24'hFEDCBA},
        {24'h800000, 24'h7FFFFF},
        {24'hFFFFFF, 24'h000000},
        {24'h400000, 24'hC00001}
    };

    function automatic logic [23:0] expv(logic [23:0] s, int g);
        longint p;
        p = longint'($signed(s)) * longint'(g) + 64'sd2048;
        return 24'(p >>> 12);
    endfunction

    function automatic int step_of(logic [1:0] sp);
        case (sp)
            2'b00:   return 4;
            2'b01:   return 2;
            default: return 1;
        endcase
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One frame: drive, strobe, update model, compare outputs and flag.
    task automatic frame(input logic [23:0] l, input logic [23:0] r, input string tag);
        logic [23:0] el, er;
        @(negedge clk);
        in_left   = l;
        in_right  = r;
        frame_stb = 1'b1;
        el = expv(l, gm);
        er = expv(r, gm);
        if (mute_req) gm = (gm > step_of(speed_sel)) ? gm - step_of(speed_sel) : 0;
        else          gm = (4096 - gm > step_of(speed_sel)) ? gm + step_of(speed_sel) : 4096;
        @(negedge clk);
        frame_stb = 1'b0;
        check(out_left == el, {tag, " R6 left"}, out_left, el);
        check(out_right == er, {tag, " R7 right"}, out_right, er);
        check(full_atten == (gm == 0), {tag, " R10 flag"}, full_atten, gm == 0);
    endtask

    // Runs a fade until the flag changes to target; returns frames taken.
    task automatic fade(input bit to_floor, input int limit, input string tag, output int took);
        took = -1;
        for (int i = 1; i <= limit; i++) begin
            frame(24'h7FFFFF, 24'h800000, tag);
            if (to_floor && full_atten && took < 0) took = i;
            if (!to_floor && out_left == 24'h7FFFFF && took < 0) took = i;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int took;
        logic [23:0] hl, hr;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_left == 24'h0, "R1 out_left reset", out_left, 0);
        check(out_right == 24'h0, "R1 out_right reset", out_right, 0);
        check(full_atten == 1'b0, "R1 flag reset", full_atten, 0);

        // R8 / R7: table at unity gain
        for (int v = 0; v < NVEC; v++) begin
            frame(UNITY_VEC[v][47:24], UNITY_VEC[v][23:0], "R8 unity table");
            check(out_left == UNITY_VEC[v][47:24], "R8 unity left exact", out_left, UNITY_VEC[v][47:24]);
            check(out_right == UNITY_VEC[v][23:0], "R8 unity right exact", out_right, UNITY_VEC[v][23:0]);
        end

        // R2: normal fade length
        mute_req = 1'b1;
        speed_sel = 2'b00;
        fade(1'b1, 1030, "R2 normal fade", took);
        check(took == 1024, "R2 normal fade frames", took, 1024);
        check(out_left == 24'h0 && out_right == 24'h0, "R8 floor silent", out_left, 0);

        // R9: no strobe, inputs and request change, nothing moves
        hl = out_left;
        hr = out_right;
        @(negedge clk);
        mute_req = 1'b0;
        in_left  = 24'h5A5A5A;
        in_right = 24'hA5A5A5;
        repeat (8) @(negedge clk);
        check(out_left == hl && out_right == hr, "R9 outputs hold", out_left, hl);
        check(full_atten == 1'b1, "R9 flag holds at floor", full_atten, 1);

        // R4 / R10: release from zero, same length
        fade(1'b0, 1030, "R4 normal release", took);
        check(took == 1025, "R4 release frames (unity seen one frame later)", took, 1025);

        // R5: early release turns around
        mute_req = 1'b1;
        for (int i = 0; i < 100; i++) frame(24'h7FFFFF, 24'h800000, "R5 partial fade");
        check(full_atten == 1'b0, "R5 not at floor", full_atten, 0);
        mute_req = 1'b0;
        for (int i = 0; i < 100; i++) frame(24'h7FFFFF, 24'h800000, "R5 climb back");
        frame(24'h7FFFFF, 24'h800000, "R5 probe");
        check(out_left == 24'h7FFFFF, "R5 back at unity after equal frames", out_left, 24'h7FFFFF);

        // R3: double speed
        mute_req = 1'b1;
        speed_sel = 2'b01;
        fade(1'b1, 2050, "R3 double fade", took);
        check(took == 2048, "R3 double fade frames", took, 2048);
        mute_req = 1'b0;
        fade(1'b0, 2050, "R3 double release", took);
        check(took == 2049, "R3 double release frames", took, 2049);

        // R3: quad speed
        mute_req = 1'b1;
        speed_sel = 2'b10;
        fade(1'b1, 4098, "R3 quad fade", took);
        check(took == 4096, "R3 quad fade frames", took, 4096);
        mute_req = 1'b0;
        speed_sel = 2'b11;
        fade(1'b0, 4098, "R3 code 11 release as quad", took);
        check(took == 4097, "R3 code 11 release frames", took, 4097);

        // R1: reset in mid fade
        mute_req = 1'b1;
        speed_sel = 2'b00;
        for (int i = 0; i < 50; i++) frame(24'h123456, 24'h654321, "R6 mid fade");
        @(negedge clk);
        rst = 1'b1;
        mute_req = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        gm = 4096;
        check(out_left == 24'h0 && out_right == 24'h0, "R1 mid-fade reset clears outputs", out_left, 0);
        frame(24'h7FFFFF, 24'h800000, "R1 after reset");
        check(out_left == 24'h7FFFFF, "R1 gain unity after reset", out_left, 24'h7FFFFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule